// File: doc/BRIEF.md
# Half-Duplex Bidirectional Line Repeater

This block relays a half-duplex serial data line between a host-side port and a card-side port. Each port is an open-drain line. The block sees the line level on an input pin and has an output pin that pulls the line low when asserted. A pull-up outside the block returns a released line to high. The block does not decide the direction ahead of time. While it sits in neutral, the first port that shows a falling edge becomes the input, and the block drives the other port to copy it. When the input port rises again, the block releases the output port and goes back to neutral. The block instantiates one lane for the main data line and `NUM_AUX` identical lanes for auxiliary lines, all from the same lane module.

All line inputs pass through a two-flop synchronizer and then an edge detector. The falling and rising propagation delays are set as clock-cycle counts (`HL_CYC`, `LH_CYC`). These model about 100 ns and about 25 ns at a 200 MHz clock. While `rx_en` is low, every lane is held in its off state: the card line is pulled low and the host line is released. Setting `rx_en` high releases the card lines and puts every lane in neutral.

Each lane has one state machine with the following states:
- `ST_OFF`: reception is off and the card line is held low.
- `ST_IDLE`: neutral; neither side is driven.
- `ST_C2H_FALL`, `ST_C2H_HOLD`, `ST_C2H_RISE`: card-to-host. FALL is the high-to-low delay, HOLD drives the host line low, and RISE is the low-to-high delay.
- `ST_H2C_FALL`, `ST_H2C_HOLD`, `ST_H2C_RISE`: the same three phases in the host-to-card direction.

The transitions are:
- OFF to IDLE when `rx_en` is high.
- IDLE to C2H_FALL on a card falling edge. Otherwise IDLE to H2C_FALL on a host falling edge.
- FALL to HOLD when the `HL_CYC` count completes.
- FALL to IDLE on a rise of the input port during the count.
- HOLD to RISE on a rise of the input port.
- RISE to IDLE when the `LH_CYC` count completes.
- Any state to OFF while `rx_en` is low. This transition takes priority over all others.

Top module: `hdx_line_relay`

## Requirements
- R1: When reset is released with `rx_en` low, every lane has `card_pull_lo`=1, `host_pull_lo`=0 and status 2'b00.
- R2: While `rx_en` is low, falling edges on a host line are not relayed: the card side stays pulled low, the host side stays released and the status stays 2'b00.
- R3: On the first clock edge that samples `rx_en` high, every lane releases its card line (`card_pull_lo`=0) and enters neutral.
- R4: In neutral, the first port with a falling edge becomes the input port, and the other port is the only side the block drives. The lane status `dir_status[2*i+1:2*i]` is 2'b00 for neutral, 2'b01 for card-to-host and 2'b10 for host-to-card. The value 2'b11 never occurs.
- R5: If an input line falls between two clock edges, the output pull-low asserts on the (`HL_CYC`+3)th rising edge after the fall. This is two synchronizer cycles, one edge-detect cycle and `HL_CYC` delay cycles.
- R6: If the input line rises, the output pull-low is released on the (`LH_CYC`+3)th rising edge after the rise, and the status returns to 2'b00 on that same edge.
- R7: If the card line and the host line fall in the same cycle while the lane is neutral, the card side becomes the input (status 2'b01).
- R8: While a direction is held, edges on the output port are ignored. This includes the block's own drive echo. The status can only return to 2'b00; it never flips directly to the other direction.
- R9: Any edge that samples `rx_en` low puts every lane into the off state (card pulled low, host released, status 2'b00), even in the middle of a transfer.
- R10: Lanes are independent. Transfers on different lanes, in opposite directions at the same time, do not affect each other or an idle lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Reception enable; low holds all lanes off |
| host_in | input | NUM_AUX+1 | Host-side line levels; bit 0 is the main data line |
| card_in | input | NUM_AUX+1 | Card-side line levels |
| host_pull_lo | output | NUM_AUX+1 | 1 pulls the host-side line low |
| card_pull_lo | output | NUM_AUX+1 | 1 pulls the card-side line low |
| dir_status | output | 2*(NUM_AUX+1) | Per-lane direction code, 2 bits per lane |

## Verification
The bench measures the exact number of edges between a line change and the output pull changing, in both directions and on more than one lane. A design with a miscounted synchronizer or delay counter shows up as an off-by-one latency. Falling edges on both ports in the same cycle check the card-side priority; a design with the wrong priority locks host-to-card and pulls the card line low. The bench also drops `rx_en` in the middle of a transfer. A design that waits for the transfer to finish leaves the host line pulled low instead of returning to the off state. Host edges while reception is off, and glitches on the output port, check that neither is relayed. A design that reacted to them would flip direction or drive the wrong side.

// File: rtl/hdx_relay_pkg.sv
`timescale 1ns/1ps
package hdx_relay_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_C2H_FALL,
        ST_C2H_HOLD,
        ST_C2H_RISE,
        ST_H2C_FALL,
        ST_H2C_HOLD,
        ST_H2C_RISE
    } relay_state_e;

    localparam logic [1:0] DIR_NONE = 2'b00;
    localparam logic [1:0] DIR_C2H  = 2'b01;
    localparam logic [1:0] DIR_H2C  = 2'b10;

endpackage

// File: rtl/hdx_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for one asynchronous line level.
module hdx_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hdx_relay_lane.sv
`timescale 1ns/1ps
// One relay lane: direction state machine with fall/rise delay phases.
module hdx_relay_lane
    import hdx_relay_pkg::*;
#(
    parameter int HL_CYC = 20,
    parameter int LH_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       host_in,
    input  logic       card_in,
    output logic       host_pull_lo,
    output logic       card_pull_lo,
    output logic [1:0] dir_code
);
    localparam int MAXD = (HL_CYC > LH_CYC) ? HL_CYC : LH_CYC;
    localparam int CW   = $clog2(MAXD + 1);

    logic host_s, card_s, host_q, card_q;
    logic host_fall, card_fall, host_rise, card_rise;
    logic hl_done, lh_done;
    logic [CW-1:0] cnt;
    relay_state_e  st, st_nx;

    hdx_sync #(.RST_VAL(1'b1)) u_sync_host (.clk(clk), .rst_n(rst_n), .d(host_in), .q(host_s));
    hdx_sync #(.RST_VAL(1'b1)) u_sync_card (.clk(clk), .rst_n(rst_n), .d(card_in), .q(card_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q <= 1'b1;
            card_q <= 1'b1;
        end else begin
            host_q <= host_s;
            card_q <= card_s;
        end
    end

    assign host_fall = host_q & ~host_s;
    assign card_fall = card_q & ~card_s;
    assign host_rise = ~host_q & host_s;
    assign card_rise = ~card_q & card_s;
    assign hl_done   = (cnt == CW'(HL_CYC - 1));
    assign lh_done   = (cnt == CW'(LH_CYC - 1));

    // State register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st) ? '0 : cnt + CW'(1);
        end
    end

    // Next state
    always_comb begin
        st_nx = st;
        if (!rx_en) begin
            st_nx = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:      st_nx = ST_IDLE;
                ST_IDLE: begin
                    if (card_fall)      st_nx = ST_C2H_FALL;
                    else if (host_fall) st_nx = ST_H2C_FALL;
                end
                ST_C2H_FALL: begin
                    if (card_rise)    st_nx = ST_IDLE;
                    else if (hl_done) st_nx = ST_C2H_HOLD;
                end
                ST_C2H_HOLD: if (card_rise) st_nx = ST_C2H_RISE;
                ST_C2H_RISE: if (lh_done)   st_nx = ST_IDLE;
                ST_H2C_FALL: begin
                    if (host_rise)    st_nx = ST_IDLE;
                    else if (hl_done) st_nx = ST_H2C_HOLD;
                end
                ST_H2C_HOLD: if (host_rise) st_nx = ST_H2C_RISE;
                ST_H2C_RISE: if (lh_done)   st_nx = ST_IDLE;
                default:     st_nx = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        host_pull_lo = 1'b0;
        card_pull_lo = 1'b0;
        dir_code     = DIR_NONE;
        unique case (st)
            ST_OFF:      card_pull_lo = 1'b1;
            ST_IDLE:     ;
            ST_C2H_FALL: dir_code = DIR_C2H;
            ST_C2H_HOLD, ST_C2H_RISE: begin
                host_pull_lo = 1'b1;
                dir_code     = DIR_C2H;
            end
            ST_H2C_FALL: dir_code = DIR_H2C;
            ST_H2C_HOLD, ST_H2C_RISE: begin
                card_pull_lo = 1'b1;
                dir_code     = DIR_H2C;
            end
            default:     card_pull_lo = 1'b1;
        endcase
    end
endmodule

// File: rtl/hdx_line_relay.sv
`timescale 1ns/1ps
// Main data lane plus NUM_AUX auxiliary lanes built from one lane module.
module hdx_line_relay #(
    parameter int NUM_AUX = 2,
    parameter int HL_CYC  = 20,
    parameter int LH_CYC  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_en,
    input  logic [NUM_AUX:0]       host_in,
    input  logic [NUM_AUX:0]       card_in,
    output logic [NUM_AUX:0]       host_pull_lo,
    output logic [NUM_AUX:0]       card_pull_lo,
    output logic [2*NUM_AUX+1:0]   dir_status
);
    localparam int NLANE = NUM_AUX + 1;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        hdx_relay_lane #(.HL_CYC(HL_CYC), .LH_CYC(LH_CYC)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .rx_en        (rx_en),
            .host_in      (host_in[i]),
            .card_in      (card_in[i]),
            .host_pull_lo (host_pull_lo[i]),
            .card_pull_lo (card_pull_lo[i]),
            .dir_code     (dir_status[2*i +: 2])
        );
    end
endmodule

// File: rtl/hdx_relay_chk.sv
`timescale 1ns/1ps
module hdx_relay_chk #(
    parameter int NUM_AUX = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic [NUM_AUX:0]     host_pull_lo,
    input logic [NUM_AUX:0]     card_pull_lo,
    input logic [2*NUM_AUX+1:0] dir_status
);
    for (genvar i = 0; i <= NUM_AUX; i++) begin : g_chk
        a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            dir_status[2*i +: 2] != 2'b11);
        a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_pull_lo[i] && card_pull_lo[i]));
        a_r4_host_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
            host_pull_lo[i] |-> dir_status[2*i +: 2] == 2'b01);
        a_r8_no_flip_c2h: assert property (@(posedge clk) disable iff (!rst_n)
            dir_status[2*i +: 2] == 2'b01 |=> dir_status[2*i +: 2] != 2'b10);
        a_r8_no_flip_h2c: assert property (@(posedge clk) disable iff (!rst_n)
            dir_status[2*i +: 2] == 2'b10 |=> dir_status[2*i +: 2] != 2'b01);
        a_r9_off_state: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_en |=> (card_pull_lo[i] && !host_pull_lo[i] && dir_status[2*i +: 2] == 2'b00));
        a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_en) |=> !card_pull_lo[i]);
    end
endmodule

bind hdx_line_relay hdx_relay_chk #(.NUM_AUX(NUM_AUX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .host_pull_lo (host_pull_lo),
    .card_pull_lo (card_pull_lo),
    .dir_status   (dir_status)
);

// File: tb/hdx_line_relay_tb.sv
`timescale 1ns/1ps
module hdx_line_relay_tb;
    localparam int NA = 2;
    localparam int NL = NA + 1;
    localparam int HL = 20;
    localparam int LH = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic [NL-1:0] tb_host_pull = '0;
    logic [NL-1:0] tb_card_pull = '0;
    logic [NL-1:0] host_line, card_line, host_pull_lo, card_pull_lo;
    logic [2*NL-1:0] dir_status;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // wired-AND lines with pull-ups
    assign host_line = ~(host_pull_lo | tb_host_pull);
    assign card_line = ~(card_pull_lo | tb_card_pull);

    hdx_line_relay #(.NUM_AUX(NA), .HL_CYC(HL), .LH_CYC(LH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .host_in(host_line), .card_in(card_line),
        .host_pull_lo(host_pull_lo), .card_pull_lo(card_pull_lo),
        .dir_status(dir_status)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_pull(input bit host_side, input int ch, input bit val, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (((host_side ? host_pull_lo[ch] : card_pull_lo[ch]) != val) && n < 200);
    endtask

    function automatic int st_of(input int ch);
        return int'(dir_status[2*ch +: 2]);
    endfunction

    task automatic t_reset();
        chk("R1", "card pulls after reset", int'(card_pull_lo), (1 << NL) - 1);
        chk("R1", "host pulls after reset", int'(host_pull_lo), 0);
        chk("R1", "status after reset", int'(dir_status), 0);
    endtask

    task automatic t_off_ignore();
        tb_host_pull[0] = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2", "card held low while off", int'(card_pull_lo), (1 << NL) - 1);
        chk("R2", "status while off", int'(dir_status), 0);
        tb_host_pull[0] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2", "host released while off", int'(host_pull_lo), 0);
    endtask

    task automatic t_enable();
        rx_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "card released on enable", int'(card_pull_lo), 0);
        chk("R3", "neutral after enable", int'(dir_status), 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_card_xfer(input int ch);
        int n;
        tb_card_pull[ch] = 1'b1;
        wait_pull(1'b1, ch, 1'b1, n);
        chk("R5", "card->host fall latency", n, HL + 3);
        chk("R4", "card->host status", st_of(ch), 1);
        chk("R4", "card side not driven", int'(card_pull_lo[ch]), 0);
        tb_host_pull[ch] = 1'b1;
        repeat (8) @(negedge clk);
        tb_host_pull[ch] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8", "status after output-side activity", st_of(ch), 1);
        chk("R8", "card side still undriven", int'(card_pull_lo[ch]), 0);
        tb_card_pull[ch] = 1'b0;
        wait_pull(1'b1, ch, 1'b0, n);
        chk("R6", "card->host rise latency", n, LH + 3);
        chk("R6", "neutral after release", st_of(ch), 0);
        repeat (6) @(negedge clk);
        chk("R8", "no echo after release", st_of(ch), 0);
    endtask

    task automatic t_host_xfer(input int ch);
        int n;
        tb_host_pull[ch] = 1'b1;
        wait_pull(1'b0, ch, 1'b1, n);
        chk("R5", "host->card fall latency", n, HL + 3);
        chk("R4", "host->card status", st_of(ch), 2);
        chk("R4", "host side not driven", int'(host_pull_lo[ch]), 0);
        tb_card_pull[ch] = 1'b1;
        repeat (8) @(negedge clk);
        tb_card_pull[ch] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8", "status after card-side activity", st_of(ch), 2);
        tb_host_pull[ch] = 1'b0;
        wait_pull(1'b0, ch, 1'b0, n);
        chk("R6", "host->card rise latency", n, LH + 3);
        chk("R6", "neutral after host release", st_of(ch), 0);
        repeat (6) @(negedge clk);
        chk("R8", "no echo after host release", st_of(ch), 0);
    endtask

    task automatic t_simul();
        int n;
        tb_card_pull[0] = 1'b1;
        tb_host_pull[0] = 1'b1;
        wait_pull(1'b1, 0, 1'b1, n);
        chk("R7", "tie latency to host drive", n, HL + 3);
        chk("R7", "card wins tie", st_of(0), 1);
        chk("R7", "card not driven on tie", int'(card_pull_lo[0]), 0);
        tb_card_pull[0] = 1'b0;
        wait_pull(1'b1, 0, 1'b0, n);
        chk("R7", "tie release latency", n, LH + 3);
        tb_host_pull[0] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R7", "neutral after tie", st_of(0), 0);
    endtask

    task automatic t_disable();
        tb_card_pull[1] = 1'b1;
        repeat (HL + 6) @(negedge clk);
        chk("R9", "host driven before disable", int'(host_pull_lo[1]), 1);
        rx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "card pulls after disable", int'(card_pull_lo), (1 << NL) - 1);
        chk("R9", "host pulls after disable", int'(host_pull_lo), 0);
        chk("R9", "status after disable", int'(dir_status), 0);
        tb_card_pull[1] = 1'b0;
        repeat (6) @(negedge clk);
        rx_en = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9", "neutral after re-enable", int'(dir_status), 0);
        chk("R9", "card released after re-enable", int'(card_pull_lo), 0);
    endtask

    task automatic t_independent();
        tb_card_pull[1] = 1'b1;
        tb_host_pull[2] = 1'b1;
        repeat (HL + 4) @(negedge clk);
        chk("R10", "lane1 card->host", st_of(1), 1);
        chk("R10", "lane2 host->card", st_of(2), 2);
        chk("R10", "lane0 untouched", st_of(0), 0);
        chk("R10", "host pulls", int'(host_pull_lo), 2);
        chk("R10", "card pulls", int'(card_pull_lo), 4);
        tb_card_pull[1] = 1'b0;
        tb_host_pull[2] = 1'b0;
        repeat (LH + 8) @(negedge clk);
        chk("R10", "all neutral", int'(dir_status), 0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off_ignore();
        t_enable();
        t_card_xfer(0);
        t_host_xfer(0);
        t_card_xfer(2);
        t_host_xfer(1);
        t_simul();
        t_disable();
        t_independent();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end
endmodule